// File: doc/BRIEF.md
# Interrupt-Capable GPIO Pin Bank

This block is a bank of general-purpose pins behind a plain word-addressed register bus with separate write and read strobes. Software sets each pin's direction and output value, reads the pin's synchronized level, and selects a pull resistor and a drive-strength code for the pad. The block drives the pad control lines directly.

Every pin also has its own interrupt detector. Three per-pin control bits choose the trigger: level-sensitive or edge-sensitive, active polarity, and an option to fire on both edges. A detected event sets a sticky raw-status bit. A mask gates raw status into masked status. A single interrupt line is the OR of all masked bits, and software acknowledges an event by writing ones to the clear register.

The bank fills a 0x200-byte window. All accesses use word addresses, where word = byte offset / 4.

Top module: `gpio_bank`

## Requirements
- R1: After reset every control register and all raw status are zero. So `pad_oe`, `pad_out`, `pull_en`, `pull_up`, `drive_code` and `irq` are all low.
- R2: The output-data register (word 1, byte 0x04) and the output-enable register (word 2, byte 0x08) drive `pad_out` and `pad_oe` bit for bit. Both registers read back what was written.
- R3: Word 0 (byte 0x00) reads `pad_in` after two synchronizing flops. Read data is registered and appears on `rdata` one clock after the `rd_en` cycle; it holds until the next read.
- R4: A pin with type bit (word 3, 0x0c) = 1 is level-sensitive, whatever its dual-edge bit holds. Its polarity bit (word 5, 0x14) = 1 selects a high level and 0 selects a low level. Raw status is set again on every cycle the active level is present.
- R5: A pin with type 0 and dual-edge bit (word 4, 0x10) = 0 sets raw status on a rising synchronized edge when polarity = 1, and on a falling edge when polarity = 0.
- R6: A pin with type 0 and dual-edge 1 sets raw status on both rising and falling edges, regardless of polarity.
- R7: Masked status (word 8, 0x20) equals raw status (word 7, 0x1c) AND mask (word 6, 0x18), where a mask bit of 1 enables the pin. `irq` is the OR of masked status. Raw status keeps updating while a pin is masked.
- R8: Writing 1 to a bit of the clear register (word 9, 0x24) clears that raw bit, and writing 0 leaves it unchanged. A new event in the same cycle as a clear wins. The clear register reads zero.
- R9: `pull_en` follows the pull-enable register (word 14, 0x38). `pull_up` is high only when that pin's pull is enabled and its pull-direction bit (word 13, 0x34) is 1. A disabled pull keeps `pull_up` low whatever the direction bit holds.
- R10: Drive-code bit k of pin n is bit n of the plane register at word 22+k (bytes 0x58, 0x5c, 0x60). It appears on `drive_code[3n+k]`. The code means (mA/2)-1.
- R11: Reads of unmapped words return zero. Writes to input data, raw status and masked status change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (7) | Word address within the bank window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | NPINS (32) | Asynchronous pad levels |
| pad_oe | output | NPINS (32) | Pad output enable |
| pad_out | output | NPINS (32) | Pad output value |
| pull_en | output | NPINS (32) | Pull resistor enable |
| pull_up | output | NPINS (32) | Pull direction, 1 = up |
| drive_code | output | 3*NPINS (96) | Per-pin 3-bit drive code, pin n at bits 3n+2:3n |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: NPINS = 32 and ADDR_W = 7. This puts every register bit and both ends of the word window in reach, including the drive planes near the top of the mapped range and unmapped words up to 127. Random trigger modes are mixed across all 32 pins at once. As a result, level, single-edge and dual-edge pins sit side by side in a single status word and share one clear. Directed cases cover a clear colliding with a held level and a masked pin collecting status.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NPINS-1:0]    pad_in,
  output logic [NPINS-1:0]    pad_oe,
  output logic [NPINS-1:0]    pad_out,
  output logic [NPINS-1:0]    pull_en,
  output logic [NPINS-1:0]    pull_up,
  output logic [3*NPINS-1:0]  drive_code,
  output logic                irq
);
  localparam int W_IN   = 0;
  localparam int W_OUT  = 1;
  localparam int W_OE   = 2;
  localparam int W_TYPE = 3;
  localparam int W_DUAL = 4;
  localparam int W_POL  = 5;
  localparam int W_MASK = 6;
  localparam int W_RAW  = 7;
  localparam int W_MST  = 8;
  localparam int W_CLR  = 9;
  localparam int W_PDIR = 13;
  localparam int W_PEN  = 14;
  localparam int W_DRV  = 22;
  localparam int PLANES = 3;

  logic [NPINS-1:0] out_q, oe_q, typ_q, dual_q, pol_q, mask_q, raw_q, pdir_q, pen_q;
  logic [NPINS-1:0] drv_q [PLANES];
  logic [NPINS-1:0] s1, s2, s3;
  logic [NPINS-1:0] wd, rise, fall, lvl_hit, edg_hit, ev, clr;
  logic [31:0]      rd_val;

  assign wd   = wdata[NPINS-1:0];
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
  assign lvl_hit = typ_q & ((pol_q & s2) | (~pol_q & ~s2));
  assign edg_hit = ~typ_q & ((dual_q & (rise | fall)) |
                             (~dual_q & ((pol_q & rise) | (~pol_q & fall))));
  assign ev  = lvl_hit | edg_hit;
  assign clr = (wr_en && addr == ADDR_W'(W_CLR)) ? wd : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= pad_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0; oe_q <= '0; typ_q <= '0; dual_q <= '0; pol_q <= '0;
      mask_q <= '0; pdir_q <= '0; pen_q <= '0;
      for (int k = 0; k < PLANES; k++) drv_q[k] <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(W_OUT))  out_q  <= wd;
      if (addr == ADDR_W'(W_OE))   oe_q   <= wd;
      if (addr == ADDR_W'(W_TYPE)) typ_q  <= wd;
      if (addr == ADDR_W'(W_DUAL)) dual_q <= wd;
      if (addr == ADDR_W'(W_POL))  pol_q  <= wd;
      if (addr == ADDR_W'(W_MASK)) mask_q <= wd;
      if (addr == ADDR_W'(W_PDIR)) pdir_q <= wd;
      if (addr == ADDR_W'(W_PEN))  pen_q  <= wd;
      for (int k = 0; k < PLANES; k++)
        if (addr == ADDR_W'(W_DRV + k)) drv_q[k] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr) | ev;
  end

  always_comb begin
    rd_val = '0;
    case (int'(addr))
      W_IN:     rd_val[NPINS-1:0] = s2;
      W_OUT:    rd_val[NPINS-1:0] = out_q;
      W_OE:     rd_val[NPINS-1:0] = oe_q;
      W_TYPE:   rd_val[NPINS-1:0] = typ_q;
      W_DUAL:   rd_val[NPINS-1:0] = dual_q;
      W_POL:    rd_val[NPINS-1:0] = pol_q;
      W_MASK:   rd_val[NPINS-1:0] = mask_q;
      W_RAW:    rd_val[NPINS-1:0] = raw_q;
      W_MST:    rd_val[NPINS-1:0] = raw_q & mask_q;
      W_PDIR:   rd_val[NPINS-1:0] = pdir_q;
      W_PEN:    rd_val[NPINS-1:0] = pen_q;
      W_DRV:    rd_val[NPINS-1:0] = drv_q[0];
      W_DRV+1:  rd_val[NPINS-1:0] = drv_q[1];
      W_DRV+2:  rd_val[NPINS-1:0] = drv_q[2];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assign pad_oe  = oe_q;
  assign pad_out = out_q;
  assign pull_en = pen_q;
  assign pull_up = pen_q & pdir_q;
  assign irq     = |(raw_q & mask_q);

  for (genvar n = 0; n < NPINS; n++) begin : g_drv
    assign drive_code[3*n +: 3] = {drv_q[2][n], drv_q[1][n], drv_q[0][n]};
  end

  assert_clear_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(W_CLR)) |=> ((raw_q & $past(wd) & ~$past(ev)) == '0));
  assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((raw_q & $past(ev)) == $past(ev)));
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(ev)) == '0));
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  assert_pen_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(W_PEN)) |=> (pull_en == $past(wd)));
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) > W_DRV + 2) |=> (rdata == '0));
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  localparam int NP = 32;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] pad_in = '0, pad_oe, pad_out, pull_en, pull_up;
  logic [3*NP-1:0] drive_code;
  logic irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bank u0 (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
                .pad_in, .pad_oe, .pad_out, .pull_en, .pull_up, .drive_code, .irq);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 7'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = 7'(a);
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [NP-1:0] exp_raw(input logic [NP-1:0] t, dl, p, o, nw);
    logic [NP-1:0] lv, ed;
    lv = t & ((p & o) | (~p & ~o) | (p & nw) | (~p & ~nw));
    ed = ~t & (o ^ nw) & (dl | (p & nw) | (~p & ~nw));
    return lv | ed;
  endfunction

  function automatic logic [3*NP-1:0] exp_drv(input logic [NP-1:0] a, b, c);
    logic [3*NP-1:0] v;
    for (int n = 0; n < NP; n++) v[3*n +: 3] = {c[n], b[n], a[n]};
    return v;
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] d, m_out, m_oe, m_pdir, m_pen, m_mask, m_d0, m_d1, m_d2;
    logic [31:0] t, dl, p, o, nw, er;
    int unsigned seed;
    seed = $urandom(32'd4711);
    idle(3); rst_n = 1; idle(1);

    // R1 reset state
    chk(pad_oe == 0 && pad_out == 0, "R1 pads", {pad_oe, pad_out}, 0);
    chk(pull_en == 0 && pull_up == 0, "R1 pulls", {pull_en, pull_up}, 0);
    chk(drive_code == 0 && irq == 0, "R1 drive/irq", {drive_code, irq}, 0);
    rd(7, d); chk(d == 0, "R1 raw", d, 0);

    // R2 direction/data
    wr(1, 32'hA5A5_0F0F); wr(2, 32'hFFFF_0000);
    chk(pad_out == 32'hA5A5_0F0F, "R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk(pad_oe == 32'hFFFF_0000, "R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(2, d); chk(d == 32'hFFFF_0000, "R2 oe readback", d, 32'hFFFF_0000);

    // R3 input sync, latency of two flops
    @(negedge clk); pad_in = 32'h1234_5678;
    @(negedge clk); rd_en = 1; addr = 0;
    @(negedge clk); rd_en = 0;
    chk(rdata == 0, "R3 not yet synchronized", rdata, 0);
    rd(0, d); chk(d == 32'h1234_5678, "R3 input", d, 32'h1234_5678);
    idle(2); chk(rdata == 32'h1234_5678, "R3 rdata holds", rdata, 32'h1234_5678);
    @(negedge clk); pad_in = '0; idle(4);

    // R4 level high on pin 0, with type+dual both set (type wins), clear vs held level (R8)
    wr(5, 32'h1); wr(4, 32'h1); wr(3, 32'h1); wr(6, 32'h1);
    idle(3); wr(9, 32'hFFFF_FFFF);
    rd(7, d); chk(d == 0, "R4 no level yet", d, 0);
    @(negedge clk); pad_in[0] = 1; idle(4);
    chk(irq == 1, "R4 level-high irq", irq, 1);
    wr(9, 32'h1); rd(7, d);
    chk(d[0] == 1, "R8 event wins over clear while level held", d, 1);
    @(negedge clk); pad_in[0] = 0; idle(4); wr(9, 32'h0);
    rd(7, d); chk(d[0] == 1, "R8 writing zero keeps status", d, 1);
    wr(9, 32'h1); rd(7, d); chk(d[0] == 0, "R8 clear after level gone", d, 0);
    rd(9, d); chk(d == 0, "R8 clear reads zero", d, 0);

    // R7 masked pin still collects raw status
    wr(6, 32'h0); wr(5, 32'h0);
    idle(2); rd(7, d);
    chk(d[0] == 1, "R7 raw updates while masked (level-low)", d, 1);
    rd(8, d); chk(d == 0, "R7 masked status zero", d, 0);
    chk(irq == 0, "R7 irq low when masked", irq, 0);

    // R11 read-only writes ignored, unmapped reads
    wr(7, 32'h0); rd(7, d); chk(d[0] == 1, "R11 raw write ignored", d, 1);
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk(d == 0, "R11 input write ignored", d, 0);
    wr(8, 32'hFFFF_FFFF); rd(8, d); chk(d == 0, "R11 mstat write ignored", d, 0);
    wr(10, 32'hFFFF_FFFF); rd(10, d); chk(d == 0, "R11 unmapped 10", d, 0);
    rd(127, d); chk(d == 0, "R11 unmapped 127", d, 0);
    wr(3, 0); wr(4, 0); wr(9, 32'hFFFF_FFFF);

    // R9 pull: direction set while disabled
    wr(13, 32'hFFFF_FFFF);
    chk(pull_up == 0, "R9 disabled pull stays low", pull_up, 0);
    wr(14, 32'h0000_FFFF);
    chk(pull_up == 32'h0000_FFFF, "R9 pull_up when enabled", pull_up, 32'h0000_FFFF);
    wr(13, 0); chk(pull_up == 0 && pull_en == 32'h0000_FFFF, "R9 pull-down", {pull_en, pull_up}, 32'h0000_FFFF);

    // R10 drive planes directed: pin 3 code 7 (16 mA), pin 5 code 2
    wr(22, 32'h8); wr(23, 32'h28); wr(24, 32'h8);
    chk(drive_code[11:9] == 3'd7 && drive_code[17:15] == 3'd2, "R10 drive directed",
        {drive_code[17:15], drive_code[11:9]}, {3'd2, 3'd7});

    // random control registers (R2, R7, R9, R10)
    m_out = 32'hA5A5_0F0F; m_oe = 32'hFFFF_0000; m_pdir = 0; m_pen = 32'h0000_FFFF;
    m_mask = 0; m_d0 = 32'h8; m_d1 = 32'h28; m_d2 = 32'h8;
    for (int i = 0; i < 40; i++) begin
      int sel;
      logic [31:0] v;
      sel = $urandom_range(0, 6); v = $urandom;
      case (sel)
        0: begin wr(1, v); m_out = v; end
        1: begin wr(2, v); m_oe = v; end
        2: begin wr(13, v); m_pdir = v; end
        3: begin wr(14, v); m_pen = v; end
        4: begin wr(22, v); m_d0 = v; end
        5: begin wr(23, v); m_d1 = v; end
        default: begin wr(24, v); m_d2 = v; end
      endcase
      chk(pad_out == m_out && pad_oe == m_oe, "R2 random pads", {pad_out, pad_oe}, {m_out, m_oe});
      chk(pull_en == m_pen && pull_up == (m_pen & m_pdir), "R9 random pulls",
          {pull_en, pull_up}, {m_pen, m_pen & m_pdir});
      chk(drive_code == exp_drv(m_d0, m_d1, m_d2), "R10 random drive",
          drive_code, exp_drv(m_d0, m_d1, m_d2));
    end

    // random trigger modes across all pins (R4 R5 R6 R7 R8)
    for (int i = 0; i < 30; i++) begin
      t = $urandom & $urandom; dl = $urandom; p = $urandom; m_mask = $urandom;
      o = $urandom; nw = $urandom;
      if (i < 4) begin t = 0; dl = (i >= 2) ? '1 : '0; p = (i % 2 == 0) ? '1 : '0; end
      wr(3, t); wr(4, dl); wr(5, p); wr(6, m_mask);
      @(negedge clk); pad_in = o; idle(5);
      wr(9, 32'hFFFF_FFFF);
      @(negedge clk); pad_in = nw; idle(5);
      er = exp_raw(t, dl, p, o, nw);
      rd(7, d);
      chk(d == er, (dl == '1) ? "R6 dual-edge raw" : "R5/R4 mixed raw", d, er);
      rd(8, d); chk(d == (er & m_mask), "R7 masked status", d, er & m_mask);
      chk(irq == |(er & m_mask), "R7 irq", irq, |(er & m_mask));
    end

    done = 1;
    summary();
  end
endmodule